// File: doc/BRIEF.md
# Round-Trip Pulse Path Delay Meter

This block sits on a central timing card and finds, once at start-up, the one-way delay of the once-per-second pulse path to each line card. For each path it raises a single-cycle marker on that path's outgoing line. It then waits for the looped-back edge, which comes home on a separate return trace, and counts the clock cycles in between. From that round trip it subtracts a return-path delay that is supplied from outside, because the outgoing and return traces are not assumed to match. What remains is the forward delay, which is later applied as a compensation at the line card.

A start pulse launches one pass over a programmable number of paths, taken strictly one after another in ascending index order. Each result goes into a small register bank as a delay value plus a valid flag, and a read index picks the entry to show. Return inputs are asynchronous: each one passes through a multi-flop synchronizer, and the fixed synchronizer latency is taken out of every measurement. A path that never answers within the timeout, or whose return delay exceeds its round trip, is stored as invalid with a delay of zero.

Top module: `pps_loop_meter`

## Requirements
- R1: After reset, busy_o and done_o are 0, mark_o is all zero, and every bank entry reads rd_vld_o=0 with rd_dly_o=0.
- R2: A run sends exactly one marker per measured path, in ascending path index order. Each marker is a single-cycle high on bit p of mark_o, and no two bits are ever high together.
- R3: The number of measured paths is path_cnt_i, sampled at start. The values 0 and anything above NUM_PATHS both select all NUM_PATHS paths. Every bank entry is cleared to invalid/zero at start, so paths that are not measured read invalid/zero.
- R4: Take the clock edge that raises the marker as edge 0. If the return input of that path rises between edge k and edge k+1, the round trip is k cycles. The synchronizer latency is already removed from this figure.
- R5: When the round trip k is within the timeout and ret_dly_i for that path (bits p*CNT_W upward) is at most k, the entry stores valid=1 and delay k minus the return delay.
- R6: Round trips up to and including TIMEOUT_CYC are accepted. If no return edge has arrived by then, the entry stores valid=0 with delay 0.
- R7: A return delay larger than the round trip gives valid=0 with delay 0 and never a wrapped value. An equal return delay gives valid=1 with delay 0.
- R8: Only a low-to-high transition on the return input of the path being measured counts. A return input that is already high, or an edge on another path's input, has no effect on the current measurement.
- R9: A start pulse while a run is in progress is ignored: no path is measured twice.
- R10: busy_o is high from the cycle after an accepted start until the run ends. done_o rises as busy_o falls, stays high while idle, and is cleared by the next accepted start.
- R11: rd_dly_o and rd_vld_o show the bank entry selected by rd_idx_i, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that launches a measurement pass |
| path_cnt_i | input | $clog2(NUM_PATHS+1) | Paths to measure, 0 meaning all |
| ret_dly_i | input | NUM_PATHS*CNT_W | Calibrated return delay per path, in cycles |
| mark_o | output | NUM_PATHS | Outgoing marker pulse, one bit per path |
| echo_i | input | NUM_PATHS | Asynchronous looped-back return, one bit per path |
| busy_o | output | 1 | A pass is running |
| done_o | output | 1 | Last pass has completed |
| rd_idx_i | input | $clog2(NUM_PATHS) | Bank entry to read |
| rd_dly_o | output | CNT_W | Forward delay of the selected entry |
| rd_vld_o | output | 1 | Selected entry holds a valid measurement |

## Verification
The bench goes after the timeout boundary by putting one return edge exactly at TIMEOUT_CYC and one a cycle later. A meter that compared off by one would either accept the late edge or drop the edge that is on time. A return delay equal to the round trip and one larger than it expose a subtractor that wraps or treats the equal case as invalid. A zero-cycle loopback, a return line held high from before the run, and a stray edge on another path's line all catch a synchronizer latency that is wrongly compensated, level-sensitive detection, and echoes merged across paths. A second start during a pass, and pass lengths of zero, five and two, show up as extra markers or stale bank entries if restart or count decoding is wrong.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

   // Sequencer states of the path delay meter
   typedef enum logic [2:0] {
      PS_IDLE = 3'd0,
      PS_SEND = 3'd1,
      PS_WAIT = 3'd2,
      PS_CALC = 3'd3,
      PS_NEXT = 3'd4,
      PS_DONE = 3'd5
   } pdm_state_e;

endpackage

// File: rtl/pdm_echo_sync.sv
module pdm_echo_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pdm_echo_sync: STAGES must be at least 2");
      end
   endgenerate

   // sh[STAGES-1] is the synchronized level, sh[STAGES] its delayed copy
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0;
      end else begin
         sh <= {sh[STAGES-1:0], async_i};
      end
   end

   assign rise_o = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/pdm_seq.sv
module pdm_seq
   import pdm_pkg::*;
#(
   parameter int NUM_PATHS   = 4,
   parameter int CNT_W       = 16,
   parameter int TIMEOUT_CYC = 200,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W  = $clog2(NUM_PATHS),
   localparam int PCNT_W = $clog2(NUM_PATHS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [PCNT_W-1:0]    path_cnt_i,
   input  logic [NUM_PATHS-1:0] rise_i,
   output logic [NUM_PATHS-1:0] mark_o,
   output logic                 busy_o,
   output logic                 done_o,
   output logic [IDX_W-1:0]     cur_idx_o,
   output logic [CNT_W-1:0]     rt_o,
   output logic                 hit_o,
   output logic                 wr_en_o,
   output logic                 clr_o
);

   localparam int TMO_LIM = TIMEOUT_CYC + SYNC_STAGES;

   generate
      if (NUM_PATHS < 2) begin : g_bad_paths
         $error("pdm_seq: NUM_PATHS must be at least 2");
      end
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_width
         $error("pdm_seq: CNT_W must lie in 2..31");
      end else if (TMO_LIM >= (1 << CNT_W)) begin : g_bad_tmo
         $error("pdm_seq: timeout plus sync latency does not fit CNT_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pdm_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   pdm_state_e           state;
   logic [IDX_W-1:0]     idx;
   logic [IDX_W-1:0]     last;
   logic [CNT_W-1:0]     cnt;
   logic [CNT_W-1:0]     rt_q;
   logic                 hit_q;
   logic                 done_q;
   logic [PCNT_W-1:0]    eff_cnt;
   logic [IDX_W-1:0]     last_d;
   logic                 sel_rise;

   // Count decode: zero or too many means every path
   always_comb begin
      if (path_cnt_i == '0 || path_cnt_i > PCNT_W'(NUM_PATHS)) begin
         eff_cnt = PCNT_W'(NUM_PATHS);
      end else begin
         eff_cnt = path_cnt_i;
      end
      last_d = IDX_W'(eff_cnt - PCNT_W'(1));
   end

   assign sel_rise = rise_i[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= PS_IDLE;
         idx    <= '0;
         last   <= '0;
         cnt    <= '0;
         rt_q   <= '0;
         hit_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         case (state)
            PS_IDLE: begin
               if (start_i) begin
                  state  <= PS_SEND;
                  idx    <= '0;
                  last   <= last_d;
                  cnt    <= '0;
                  done_q <= 1'b0;
               end
            end
            PS_SEND: begin
               cnt   <= cnt + CNT_W'(1);
               state <= PS_WAIT;
            end
            PS_WAIT: begin
               if (sel_rise) begin
                  rt_q  <= cnt - CNT_W'(SYNC_STAGES);
                  hit_q <= 1'b1;
                  state <= PS_CALC;
               end else if (cnt == CNT_W'(TMO_LIM)) begin
                  rt_q  <= '0;
                  hit_q <= 1'b0;
                  state <= PS_CALC;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            PS_CALC: begin
               state <= (idx == last) ? PS_DONE : PS_NEXT;
            end
            PS_NEXT: begin
               idx   <= idx + IDX_W'(1);
               cnt   <= '0;
               state <= PS_SEND;
            end
            PS_DONE: begin
               done_q <= 1'b1;
               state  <= PS_IDLE;
            end
            default: state <= PS_IDLE;
         endcase
      end
   end

   // One marker bit per path, high only in the send cycle
   generate
      for (genvar p = 0; p < NUM_PATHS; p++) begin : g_mark
         assign mark_o[p] = (state == PS_SEND) && (idx == IDX_W'(p));
      end
   endgenerate

   assign busy_o    = (state != PS_IDLE);
   assign done_o    = done_q;
   assign cur_idx_o = idx;
   assign rt_o      = rt_q;
   assign hit_o     = hit_q;
   assign wr_en_o   = (state == PS_CALC);
   assign clr_o     = (state == PS_IDLE) && start_i;

   AST_ONE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mark_o)); // R2
   AST_MARK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_o != '0) |=> (mark_o == '0)); // R2
   AST_TIMER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_WAIT) |-> (cnt <= CNT_W'(TMO_LIM))); // R6
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o); // R10
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R10
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |-> !clr_o); // R9

endmodule

// File: rtl/pdm_fwd_calc.sv
module pdm_fwd_calc #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rt_i,
   input  logic [CNT_W-1:0] ret_i,
   input  logic             hit_i,
   output logic [CNT_W-1:0] fwd_o,
   output logic             ok_o
);

   // Forward delay is round trip minus return leg; no wrap allowed
   always_comb begin
      ok_o  = hit_i && (ret_i <= rt_i);
      fwd_o = ok_o ? (rt_i - ret_i) : '0;
   end

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ok_o |-> (fwd_o <= rt_i)); // R7
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_i |-> (fwd_o == '0 && !ok_o)); // R6

endmodule

// File: rtl/pdm_result_bank.sv
module pdm_result_bank #(
   parameter int NUM_PATHS = 4,
   parameter int CNT_W     = 16,
   localparam int IDX_W = $clog2(NUM_PATHS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [CNT_W-1:0] wr_dly_i,
   input  logic             wr_vld_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic [CNT_W-1:0] rd_dly_o,
   output logic             rd_vld_o
);

   logic [NUM_PATHS-1:0] vld_q;
   logic [CNT_W-1:0]     dly_q [NUM_PATHS];

   generate
      for (genvar p = 0; p < NUM_PATHS; p++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[p] <= 1'b0;
               dly_q[p] <= '0;
            end else if (clr_i) begin
               vld_q[p] <= 1'b0;
               dly_q[p] <= '0;
            end else if (wr_en_i && wr_idx_i == IDX_W'(p)) begin
               vld_q[p] <= wr_vld_i;
               dly_q[p] <= wr_dly_i;
            end
         end
      end

      // Full index space needs no range guard; otherwise reads above the bank give zero
      if ((1 << IDX_W) == NUM_PATHS) begin : g_rd_full
         assign rd_dly_o = dly_q[rd_idx_i];
         assign rd_vld_o = vld_q[rd_idx_i];
      end else begin : g_rd_guard
         always_comb begin
            rd_dly_o = '0;
            rd_vld_o = 1'b0;
            for (int p = 0; p < NUM_PATHS; p++) begin
               if (rd_idx_i == IDX_W'(p)) begin
                  rd_dly_o = dly_q[p];
                  rd_vld_o = vld_q[p];
               end
            end
         end
      end
   endgenerate

   AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (vld_q == '0)); // R3

endmodule

// File: rtl/pps_loop_meter.sv
module pps_loop_meter #(
   parameter int NUM_PATHS   = 4,
   parameter int CNT_W       = 16,
   parameter int TIMEOUT_CYC = 200,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W  = $clog2(NUM_PATHS),
   localparam int PCNT_W = $clog2(NUM_PATHS + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [PCNT_W-1:0]          path_cnt_i,
   input  logic [NUM_PATHS*CNT_W-1:0] ret_dly_i,
   output logic [NUM_PATHS-1:0]       mark_o,
   input  logic [NUM_PATHS-1:0]       echo_i,
   output logic                       busy_o,
   output logic                       done_o,
   input  logic [IDX_W-1:0]           rd_idx_i,
   output logic [CNT_W-1:0]           rd_dly_o,
   output logic                       rd_vld_o
);

   logic [NUM_PATHS-1:0] rise;
   logic [CNT_W-1:0]     ret_arr [NUM_PATHS];
   logic [IDX_W-1:0]     cur_idx;
   logic [CNT_W-1:0]     rt;
   logic                 hit;
   logic                 wr_en;
   logic                 clr;
   logic [CNT_W-1:0]     fwd;
   logic                 fwd_ok;

   generate
      for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
         pdm_echo_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (echo_i[p]),
            .rise_o  (rise[p])
         );
         assign ret_arr[p] = ret_dly_i[p*CNT_W +: CNT_W];
      end
   endgenerate

   pdm_seq #(
      .NUM_PATHS   (NUM_PATHS),
      .CNT_W       (CNT_W),
      .TIMEOUT_CYC (TIMEOUT_CYC),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .path_cnt_i (path_cnt_i),
      .rise_i     (rise),
      .mark_o     (mark_o),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .cur_idx_o  (cur_idx),
      .rt_o       (rt),
      .hit_o      (hit),
      .wr_en_o    (wr_en),
      .clr_o      (clr)
   );

   pdm_fwd_calc #(.CNT_W(CNT_W)) u_calc (
      .clk   (clk),
      .rst_n (rst_n),
      .rt_i  (rt),
      .ret_i (ret_arr[cur_idx]),
      .hit_i (hit),
      .fwd_o (fwd),
      .ok_o  (fwd_ok)
   );

   pdm_result_bank #(
      .NUM_PATHS (NUM_PATHS),
      .CNT_W     (CNT_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr),
      .wr_en_i  (wr_en),
      .wr_idx_i (cur_idx),
      .wr_dly_i (fwd),
      .wr_vld_i (fwd_ok),
      .rd_idx_i (rd_idx_i),
      .rd_dly_o (rd_dly_o),
      .rd_vld_o (rd_vld_o)
   );

   AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_vld_o |-> (rd_dly_o == '0)); // R6

endmodule

// File: tb/pps_loop_meter_tb.sv
module pps_loop_meter_tb;
   localparam int NP  = 4;
   localparam int CW  = 16;
   localparam int TMO = 200;
   localparam int SS  = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [2:0]       pcnt = '0;
   logic [NP*CW-1:0] retv = '0;
   logic [NP-1:0]    mark;
   logic [NP-1:0]    echo = '0;
   logic             busy, done;
   logic [1:0]       rd_idx = '0;
   logic [CW-1:0]    rd_dly;
   logic             rd_vld;

   always #5 clk = ~clk;

   pps_loop_meter #(.NUM_PATHS(NP), .CNT_W(CW), .TIMEOUT_CYC(TMO), .SYNC_STAGES(SS)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .path_cnt_i(pcnt), .ret_dly_i(retv),
      .mark_o(mark), .echo_i(echo), .busy_o(busy), .done_o(done),
      .rd_idx_i(rd_idx), .rd_dly_o(rd_dly), .rd_vld_o(rd_vld));

   int dly [NP];
   bit en [NP];
   int ret [NP];
   bit pre_hi [NP];
   bit spur;
   bit load_req;
   int mark_cnt [NP];
   int el [NP];
   bit armed [NP];
   int last_mark;
   bit order_bad;
   int spur_cnt;
   int errors = 0;
   int checks = 0;

   // Loopback model and marker monitor, all on the falling edge
   always @(negedge clk) begin
      if (load_req) begin
         for (int p = 0; p < NP; p++) begin
            echo[p] = pre_hi[p];
            armed[p] = 1'b0;
            mark_cnt[p] = 0;
         end
         last_mark = -1;
         order_bad = 1'b0;
         spur_cnt = 0;
      end else begin
         for (int p = 0; p < NP; p++) begin
            if (mark[p]) begin
               mark_cnt[p]++;
               if (p <= last_mark) order_bad = 1'b1;
               last_mark = p;
               el[p] = 0;
               armed[p] = en[p];
            end else if (armed[p]) begin
               el[p]++;
            end
            if (armed[p] && el[p] == dly[p]) begin
               echo[p] = 1'b1;
               armed[p] = 1'b0;
            end
         end
         if (spur && mark[0]) spur_cnt = 1;
         else if (spur_cnt > 0) spur_cnt++;
         if (spur_cnt == 5) echo[3] = 1'b1;
         if (spur_cnt == 9) begin
            echo[3] = 1'b0;
            spur_cnt = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string msg, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
      end
   endtask

   task automatic cfg(input int p, input int d, input bit e, input int r);
      dly[p] = d; en[p] = e; ret[p] = r; pre_hi[p] = 1'b0;
   endtask

   function automatic int exp_vld(input int p, input int eff);
      if (p >= eff || !en[p] || dly[p] > TMO || ret[p] > dly[p]) return 0;
      return 1;
   endfunction

   function automatic int exp_dly(input int p, input int eff);
      return exp_vld(p, eff) ? dly[p] - ret[p] : 0;
   endfunction

   task automatic run(input int pc, input bit restart, input string tag);
      int eff;
      int g;
      @(negedge clk);
      for (int p = 0; p < NP; p++) retv[p*CW +: CW] = CW'(ret[p]);
      load_req = 1'b1;
      repeat (2) @(negedge clk);
      load_req = 1'b0;
      repeat (6) @(negedge clk);
      pcnt = 3'(pc);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R10 busy after start", int'(busy), 1);
      chk(done === 1'b0, "R10 done cleared by start", int'(done), 0);
      if (restart) begin
         repeat (30) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      g = 0;
      while (!done && g < 5000) begin
         @(negedge clk);
         g++;
      end
      chk(done === 1'b1, "R10 done at end of pass", int'(done), 1);
      chk(busy === 1'b0, "R10 busy low at end", int'(busy), 0);
      eff = (pc == 0 || pc > NP) ? NP : pc;
      for (int p = 0; p < NP; p++) begin
         chk(mark_cnt[p] == ((p < eff) ? 1 : 0),
             restart ? "R9 markers per path" : "R2 R3 markers per path",
             mark_cnt[p], (p < eff) ? 1 : 0);
      end
      chk(!order_bad, "R2 ascending path order", int'(order_bad), 0);
      for (int p = 0; p < NP; p++) begin
         rd_idx = 2'(p);
         #1;
         chk(int'(rd_vld) == exp_vld(p, eff), {tag, " R11 valid"}, int'(rd_vld), exp_vld(p, eff));
         chk(int'(rd_dly) == exp_dly(p, eff), {tag, " R11 delay"}, int'(rd_dly), exp_dly(p, eff));
      end
   endtask

   initial begin
      bit wd;
      wd = 1'b0;
      load_req = 1'b0;
      spur = 1'b0;
      for (int p = 0; p < NP; p++) cfg(p, 0, 1'b0, 0);
      void'($urandom(32'h5EED_1588));
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
            chk(done === 1'b0, "R1 done after reset", int'(done), 0);
            chk(mark == '0, "R1 marker after reset", int'(mark), 0);
            for (int p = 0; p < NP; p++) begin
               rd_idx = 2'(p);
               #1;
               chk(rd_vld === 1'b0 && rd_dly == '0, "R1 bank empty", int'(rd_dly), 0);
            end

            // Basic pass: normal, equal return, underflow, zero return delay
            cfg(0, 10, 1'b1, 4);
            cfg(1, 25, 1'b1, 25);
            cfg(2, 3, 1'b1, 5);
            cfg(3, 40, 1'b1, 0);
            run(4, 1'b0, "R4 R5 R7");

            // Timeout boundary, zero loopback, silent path, count 0 means all
            cfg(0, TMO, 1'b1, 0);
            cfg(1, TMO + 1, 1'b1, 0);
            cfg(2, 0, 1'b1, 0);
            cfg(3, 5, 1'b0, 0);
            run(0, 1'b0, "R3 R6");

            // Short pass over two paths with a second start mid-run
            cfg(0, 60, 1'b1, 7);
            cfg(1, 70, 1'b1, 9);
            cfg(2, 12, 1'b1, 0);
            cfg(3, 12, 1'b1, 0);
            run(2, 1'b1, "R3 R9");

            // Held-high return line and a stray edge on another path
            cfg(0, 20, 1'b1, 5);
            cfg(1, 8, 1'b0, 0);
            pre_hi[1] = 1'b1;
            cfg(2, 7, 1'b1, 2);
            cfg(3, 9, 1'b1, 1);
            spur = 1'b1;
            run(4, 1'b0, "R8");
            spur = 1'b0;

            // Count above the path total selects all paths
            for (int p = 0; p < NP; p++) cfg(p, 15 + p, 1'b1, p);
            run(5, 1'b0, "R3 over-count");

            // Constrained random passes
            for (int i = 0; i < 25; i++) begin
               for (int p = 0; p < NP; p++) begin
                  int d;
                  d = int'($urandom_range(TMO + 3, 0));
                  cfg(p, d, $urandom_range(9, 0) != 0, int'($urandom_range(d + 10, 0)));
               end
               run(int'($urandom_range(5, 0)), 1'b0, "R4 R5 random");
            end
         end
         begin
            repeat (150000) @(posedge clk);
            wd = 1'b1;
         end
      join_any
      disable fork;
      if (wd) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule